// File: doc/BRIEF.md
# Synchroniser Operating-Mode Controller

This block is the control state machine of a network-element clock. It decides whether the clock's phase-locked loop tracks a reference, freezes its frequency, or runs from the local oscillator. It reports that decision as a state code, a holdover flag, a lock flag and a hold-frequency command to the loop. Software or pins request a mode and a reference through two fields. The block captures those fields only on the rising edge of an 8 kHz frame strobe, so a request takes effect on a frame boundary.

There are five states: Reset, Free-run, Normal, Holdover and Auto-holdover. The named transitions are:
- reset exit (Reset to Free-run);
- forced free-run (any state to Free-run);
- acquisition (Free-run to Holdover);
- lock-in (Holdover to Normal, on a lock pulse from the loop);
- reference loss (Normal to Auto-holdover);
- fast recovery (Auto-holdover to Normal);
- slow recovery (Auto-holdover to Holdover, when the lost reference is the 8 kHz one);
- reselect detour (Normal to Holdover, when a different reference is captured);
- manual hold (Normal or Auto-holdover to Holdover).

The loop, the frequency monitors and any register access sit outside this block.

Top module: `smode_ctrl`

## Requirements
- R1: The `state_o` codes are 0 for Reset, 1 for Free-run, 2 for Normal, 3 for Holdover and 4 for Auto-holdover. While `rst_n` is low, the state is 0 and all flags are low. The first clock edge after release moves the state to 1.
- R2: `mode_sel` and `ref_sel` are captured only at a clock edge where `frame_strobe` is high and was low at the previous edge. At all other times their changes have no effect. The mode codes are 00 for Normal, 01 for Holdover, and 10 or 11 for Free-run. The captured mode starts as Free-run after reset.
- R3: A captured Free-run code moves any non-Reset state to Free-run at the next edge. This takes priority over every other transition.
- R4: Free-run with a captured 00 or 01 moves to Holdover. Holdover moves to Normal only when the captured mode is 00, `lock_done` is high and `ref_fail` is low.
- R5: In Normal, a high `ref_fail` moves the state to Auto-holdover. This wins over a reference change seen in the same cycle.
- R6: In Auto-holdover, with `ref_fail` low, `ref_is_8k` low and captured mode 00, the state returns to Normal if `ahold_dis` is low. It stays in Auto-holdover if `ahold_dis` is high.
- R7: In Auto-holdover, with `ref_fail` low and `ref_is_8k` high, the state moves to Holdover rather than to Normal.
- R8: In Normal, capturing a `ref_sel` value that differs from the previously captured one moves the state to Holdover. A captured 01 in Normal or Auto-holdover also moves the state to Holdover.
- R9: `lock_o` rises at the edge where `lock_done` is high, provided the state is, or becomes, Normal and `align_ok` is high. It falls at the edge where the state leaves Normal, and one edge after `align_ok` is low.
- R10: `holdover_o` is high exactly while the state is Holdover or Auto-holdover.
- R11: `hold_freq_o` is high in Auto-holdover. It is also high in Holdover when the captured mode is not 00. It is low while acquiring in Holdover under mode 00, and low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | 8 kHz frame strobe; its rising edge captures requests |
| mode_sel | input | 2 | Requested mode: 00 Normal, 01 Holdover, 1x Free-run |
| ref_sel | input | 1 | Requested reference index |
| ref_fail | input | 1 | Active reference is out of range or lost |
| ref_is_8k | input | 1 | Active reference is the 8 kHz type |
| lock_done | input | 1 | Lock-achieved pulse from the loop |
| align_ok | input | 1 | Alignment control; low drops the lock flag |
| ahold_dis | input | 1 | Blocks direct recovery from Auto-holdover |
| state_o | output | 3 | Current state code |
| holdover_o | output | 1 | Holdover or Auto-holdover flag |
| lock_o | output | 1 | Lock status flag |
| hold_freq_o | output | 1 | Command for the loop to freeze its frequency |

## Verification
Two events can reach the Normal state in the same cycle: a reference failure and a captured change of reference selection. The bench provokes this by capturing a new `ref_sel` on one edge and raising `ref_fail` so that both are visible at the next edge. The outcome is judged against Auto-holdover, because the failure must win. A second collision is a lock pulse arriving in the same cycle as a low `align_ok`. Long random runs reach both collisions repeatedly, and a bench model computes the expected state and flags for every cycle.

// File: rtl/smode_pkg.sv
package smode_pkg;
    localparam int MODE_W  = 2;
    localparam int STATE_W = 3;

    localparam logic [MODE_W-1:0] MODE_NORM = 2'b00;
    localparam logic [MODE_W-1:0] MODE_HOLD = 2'b01;
    localparam logic [MODE_W-1:0] MODE_FREE = 2'b10;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET = 3'd0,
        ST_FREE  = 3'd1,
        ST_NORM  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_AUTO  = 3'd4
    } smode_e;
endpackage

// File: rtl/smode_sampler.sv
module smode_sampler
    import smode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              ref_in,
    output logic [MODE_W-1:0] mode_q,
    output logic              ref_chg
);
    logic strobe_q;
    logic ref_q;
    logic rise;

    assign rise = strobe & ~strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            mode_q   <= MODE_FREE;
            ref_q    <= 1'b0;
            ref_chg  <= 1'b0;
        end else begin
            strobe_q <= strobe;
            ref_chg  <= rise && (ref_in != ref_q);
            if (rise) begin
                mode_q <= mode_in;
                ref_q  <= ref_in;
            end
        end
    end

    // Two capture edges can never be adjacent, so a change pulse is single-cycle (R8)
    assert_chg_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_chg |=> !ref_chg);
endmodule

// File: rtl/smode_lock.sv
module smode_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_norm,
    input  logic lock_done,
    input  logic align_ok,
    output logic lock_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (!enter_norm || !align_ok) begin
            lock_q <= 1'b0;
        end else if (lock_done) begin
            lock_q <= 1'b1;
        end
    end

    assert_align_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !align_ok |=> !lock_q);
endmodule

// File: rtl/smode_ctrl.sv
module smode_ctrl
    import smode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_strobe,
    input  logic [MODE_W-1:0]  mode_sel,
    input  logic               ref_sel,
    input  logic               ref_fail,
    input  logic               ref_is_8k,
    input  logic               lock_done,
    input  logic               align_ok,
    input  logic               ahold_dis,
    output logic [STATE_W-1:0] state_o,
    output logic               holdover_o,
    output logic               lock_o,
    output logic               hold_freq_o
);
    smode_e            state;
    smode_e            nxt;
    logic [MODE_W-1:0] mode_q;
    logic              ref_chg;
    logic              force_free;

    smode_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (frame_strobe),
        .mode_in (mode_sel),
        .ref_in  (ref_sel),
        .mode_q  (mode_q),
        .ref_chg (ref_chg)
    );

    smode_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_norm (nxt == ST_NORM),
        .lock_done  (lock_done),
        .align_ok   (align_ok),
        .lock_q     (lock_o)
    );

    assign force_free = mode_q[MODE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET: nxt = ST_FREE;
            ST_FREE: begin
                if (!force_free) nxt = ST_HOLD;
            end
            ST_NORM: begin
                if (force_free)                nxt = ST_FREE;
                else if (mode_q == MODE_HOLD)  nxt = ST_HOLD;
                else if (ref_fail)             nxt = ST_AUTO;
                else if (ref_chg)              nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (force_free)                nxt = ST_FREE;
                else if (mode_q == MODE_NORM && lock_done && !ref_fail)
                                               nxt = ST_NORM;
            end
            ST_AUTO: begin
                if (force_free)                nxt = ST_FREE;
                else if (mode_q == MODE_HOLD)  nxt = ST_HOLD;
                else if (!ref_fail && ref_is_8k)  nxt = ST_HOLD;
                else if (!ref_fail && !ahold_dis) nxt = ST_NORM;
            end
            default: nxt = ST_RESET;
        endcase
    end

    always_comb begin
        state_o     = state;
        holdover_o  = 1'b0;
        hold_freq_o = 1'b0;
        unique case (state)
            ST_HOLD: begin
                holdover_o  = 1'b1;
                hold_freq_o = (mode_q != MODE_NORM);
            end
            ST_AUTO: begin
                holdover_o  = 1'b1;
                hold_freq_o = 1'b1;
            end
            ST_RESET, ST_FREE, ST_NORM: begin
                holdover_o  = 1'b0;
                hold_freq_o = 1'b0;
            end
            default: begin
                holdover_o  = 1'b0;
                hold_freq_o = 1'b0;
            end
        endcase
    end

    assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RESET |=> state == ST_FREE);

    assert_force_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (force_free && state != ST_RESET) |=> state == ST_FREE);

    assert_fail_auto_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM && mode_q == MODE_NORM && ref_fail) |=> state == ST_AUTO);

    assert_auto_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTO && mode_q == MODE_NORM && !ref_fail && !ref_is_8k && ahold_dis)
        |=> state == ST_AUTO);

    assert_lock_in_norm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> state == ST_NORM);
endmodule

// File: tb/tb_smode_ctrl.sv
module tb_smode_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_strobe;
    logic [1:0] mode_sel;
    logic       ref_sel, ref_fail, ref_is_8k, lock_done, align_ok, ahold_dis;
    logic [2:0] state_o;
    logic       holdover_o, lock_o, hold_freq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    int         m_st = 0;
    logic [1:0] m_mode = 2'b10;
    logic       m_ref = 0, m_chg = 0, m_sq = 0, m_lock = 0;

    always #(CLK_P/2) clk = ~clk;

    smode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .mode_sel(mode_sel),
        .ref_sel(ref_sel), .ref_fail(ref_fail), .ref_is_8k(ref_is_8k),
        .lock_done(lock_done), .align_ok(align_ok), .ahold_dis(ahold_dis),
        .state_o(state_o), .holdover_o(holdover_o), .lock_o(lock_o),
        .hold_freq_o(hold_freq_o)
    );

    function automatic int f_next(int st, logic [1:0] md, logic chg, logic fail,
                                  logic ld, logic is8k, logic ahd);
        if (st == 0) return 1;
        if (md[1]) return 1;
        case (st)
            1: return 3;
            2: begin
                if (md == 2'b01) return 3;
                if (fail) return 4;
                if (chg) return 3;
                return 2;
            end
            3: return (md == 2'b00 && ld && !fail) ? 2 : 3;
            4: begin
                if (md == 2'b01) return 3;
                if (!fail && is8k) return 3;
                if (!fail && !ahd) return 2;
                return 4;
            end
            default: return 0;
        endcase
    endfunction

    function automatic logic f_hold(int st);
        return (st == 3 || st == 4);
    endfunction

    function automatic logic f_hfreq(int st, logic [1:0] md);
        return (st == 4) || (st == 3 && md != 2'b00);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_mode = 2'b10; m_ref = 0; m_chg = 0; m_sq = 0; m_lock = 0;
        end else begin
            int  nx;
            logic rise;
            nx   = f_next(m_st, m_mode, m_chg, ref_fail, lock_done, ref_is_8k, ahold_dis);
            rise = frame_strobe && !m_sq;
            if (nx != 2 || !align_ok) m_lock = 0;
            else if (lock_done)       m_lock = 1;
            m_chg = rise && (ref_sel != m_ref);
            if (rise) begin
                m_mode = mode_sel;
                m_ref  = ref_sel;
            end
            m_sq = frame_strobe;
            m_st = nx;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic capture(logic [1:0] md, logic rs);
        mode_sel = md; ref_sel = rs; frame_strobe = 1'b1;
        tick();
        frame_strobe = 1'b0;
        tick();
    endtask

    task automatic pulse_lock();
        lock_done = 1'b1;
        tick();
        lock_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        rst_n = 0; frame_strobe = 0; mode_sel = 2'b10; ref_sel = 0; ref_fail = 0;
        ref_is_8k = 0; lock_done = 0; align_ok = 1; ahold_dis = 0;
        repeat (3) tick();
        chk("R1 reset state", state_o, 0);
        chk("R1 reset holdover", holdover_o, 0);
        chk("R1 reset lock", lock_o, 0);
        rst_n = 1;
        tick();
        chk("R1 exit to free-run", state_o, 1);

        mode_sel = 2'b00;
        repeat (4) tick();
        chk("R2 no strobe no effect", state_o, 1);

        capture(2'b00, 1'b0);
        chk("R4 free-run to holdover", state_o, 3);
        chk("R10 holdover flag", holdover_o, 1);
        chk("R11 acquiring no hold", hold_freq_o, 0);
        pulse_lock();
        chk("R4 lock-in to normal", state_o, 2);
        chk("R9 lock rises", lock_o, 1);
        chk("R10 flag low in normal", holdover_o, 0);

        ref_fail = 1;
        tick();
        chk("R5 fail to auto", state_o, 4);
        chk("R9 lock drops", lock_o, 0);
        chk("R11 auto hold", hold_freq_o, 1);
        chk("R10 auto flag", holdover_o, 1);

        ahold_dis = 1; ref_fail = 0;
        tick(); tick();
        chk("R6 disabled stays auto", state_o, 4);
        ahold_dis = 0;
        tick();
        chk("R6 fast recovery", state_o, 2);
        chk("R9 no lock without pulse", lock_o, 0);
        pulse_lock();
        chk("R9 lock in normal", lock_o, 1);
        align_ok = 0;
        tick();
        chk("R9 align low drops lock", lock_o, 0);
        align_ok = 1;
        tick();
        chk("R9 stays normal", state_o, 2);

        // collision: reference change and failure in the same cycle
        mode_sel = 2'b00; ref_sel = 1; frame_strobe = 1;
        tick();
        frame_strobe = 0; ref_fail = 1;
        tick();
        chk("R5 fail beats reselect", state_o, 4);
        ref_fail = 0; ref_is_8k = 1;
        tick();
        chk("R7 8k recovery to holdover", state_o, 3);
        pulse_lock();
        chk("R7 then normal", state_o, 2);
        ref_is_8k = 0;

        capture(2'b00, 1'b0);
        chk("R8 reselect detour", state_o, 3);
        pulse_lock();
        chk("R8 back to normal", state_o, 2);

        capture(2'b01, 1'b0);
        chk("R8 manual hold", state_o, 3);
        chk("R11 manual hold freq", hold_freq_o, 1);
        pulse_lock();
        chk("R4 no lock-in under 01", state_o, 3);

        capture(2'b11, 1'b0);
        chk("R3 code 11 forces free-run", state_o, 1);
        capture(2'b00, 1'b0);
        pulse_lock();
        ref_fail = 1;
        tick();
        chk("R5 auto again", state_o, 4);
        capture(2'b10, 1'b0);
        chk("R3 auto to free-run", state_o, 1);
        ref_fail = 0;

        // strobe held high: later mode change is not a rising edge
        mode_sel = 2'b00; frame_strobe = 1;
        tick();
        mode_sel = 2'b10;
        tick(); tick(); tick();
        chk("R2 held strobe ignores change", state_o, 3);
        frame_strobe = 0;
        tick();

        // random phase against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            chk("R1 model state", state_o, m_st);
            chk("R10 model flag", holdover_o, f_hold(m_st));
            chk("R9 model lock", lock_o, m_lock);
            chk("R11 model hold", hold_freq_o, f_hfreq(m_st, m_mode));
            frame_strobe = ($urandom % 4 == 0);
            r = $urandom % 8;
            mode_sel = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
            if ($urandom % 16 == 0) ref_sel   = ~ref_sel;
            if ($urandom % 12 == 0) ref_fail  = ~ref_fail;
            if ($urandom % 20 == 0) ahold_dis = ~ahold_dis;
            if ($urandom % 20 == 0) ref_is_8k = ~ref_is_8k;
            lock_done = ($urandom % 5 == 0);
            align_ok  = ($urandom % 20 != 0);
            tick();
        end
        finish_run();
    end
endmodule